// File: doc/BRIEF.md
# Reloadable Down-Counting Tick Timer

This block is a 24-bit down-counter behind a small word-addressed register port. Software sets a reload value, enables the counter, and gets a periodic wrap event. The event sets a sticky status flag and can also raise a one-cycle interrupt request.

Each counted cycle lowers the count by one. A count that is already zero is loaded from the reload register instead. Counting happens on every clock, or only on cycles where an external reference strobe is high, depending on a source-select bit.

Reads and writes have side effects:
- Reading the control/status word clears the wrap flag.
- Writing any value to the current-count word forces the count to zero, so the next counted cycle reloads.

Top module: `sys_tick_timer`

## Requirements
- R1: The reload and current-count words (word addresses 1 and 2) hold 24 bits. Writes keep only bits 23:0, and reads return zero in bits 31:24.
- R2: On a counted cycle a nonzero count decreases by one, and a zero count loads the reload value. A reload value of N-1 gives a wrap every N counted cycles.
- R3: A counted step from 1 to 0 sets the wrap flag, which reads as bit 16 of the control/status word (word address 0).
- R4: A read of the control/status word clears the wrap flag after that cycle. If a wrap happens in the same cycle as the read, the flag stays set.
- R5: A write of any value to the current-count word makes the count zero on the next cycle. The following counted cycle then loads the reload value.
- R6: While the enable bit (bit 0 of the control word) is clear, the count holds its value.
- R7: With the interrupt-enable bit (bit 1) set, `tick_irq_o` is high for exactly one cycle: the first cycle in which the newly set wrap flag is visible. With the bit clear, no pulse is produced.
- R8: With the source bit (bit 2) set, every cycle is counted. With it clear, only cycles where `ref_tick_i` is high are counted.
- R9: After reset, the control, reload and current-count words all read zero and `tick_irq_o` is low.
- R10: Control/status reads return the three control bits as last written, the flag in bit 16, and zero in every other bit. Word address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | External reference strobe, used when the source bit is clear |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word, valid in the same cycle |
| tick_irq_o | output | 1 | One-cycle tick interrupt request |

## Verification
The assertions take two things for granted about the inputs:
- The register port carries at most one access per cycle, with the select, write, address and strobe inputs at known values after reset.
- A read and a same-cycle wrap are the only overlap that touches the flag from two sides.

The stimulus meets these conditions by driving every input once per cycle at the falling edge, issuing exactly one access or idle per cycle. Reload values are kept small, so that wraps, reads of the flag in a wrap cycle, and forced clears of the count collide often.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned TK_CNT_W  = 24;
  localparam int unsigned TK_DATA_W = 32;
  localparam int unsigned TK_ADDR_W = 2;

  // word addresses
  localparam logic [TK_ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [TK_ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [TK_ADDR_W-1:0] A_CUR    = 2'd2;

  // control/status bit positions
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_IRQE = 1;
  localparam int unsigned B_SRC  = 2;
  localparam int unsigned B_FLAG = 16;

  // next count on a counted cycle
  function automatic logic [TK_CNT_W-1:0] f_next_count(
    input logic [TK_CNT_W-1:0] cur,
    input logic [TK_CNT_W-1:0] rld
  );
    return (cur == '0) ? rld : cur - TK_CNT_W'(1);
  endfunction

  // true when a counted cycle steps 1 -> 0
  function automatic logic f_is_wrap(input logic [TK_CNT_W-1:0] cur);
    return cur == TK_CNT_W'(1);
  endfunction
endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
  import tick_pkg::*;
#(
  parameter int unsigned ADDR_W = TK_ADDR_W
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_ctrl_o,
  output logic              wr_reload_o,
  output logic              wr_cur_o,
  output logic              rd_ctrl_o
);
  always_comb begin
    wr_ctrl_o   = sel_i &&  wr_i && (addr_i == A_CTRL);
    wr_reload_o = sel_i &&  wr_i && (addr_i == A_RELOAD);
    wr_cur_o    = sel_i &&  wr_i && (addr_i == A_CUR);
    rd_ctrl_o   = sel_i && !wr_i && (addr_i == A_CTRL);
  end
endmodule

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl_i,
  input  logic rd_ctrl_i,
  input  logic run_d_i,
  input  logic irqe_d_i,
  input  logic src_d_i,
  input  logic wrap_i,
  output logic run_o,
  output logic irqe_o,
  output logic src_o,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o  <= 1'b0;
      irqe_o <= 1'b0;
      src_o  <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        run_o  <= run_d_i;
        irqe_o <= irqe_d_i;
        src_o  <= src_d_i;
      end
      // set wins over read-clear
      if (wrap_i)         flag_o <= 1'b1;
      else if (rd_ctrl_i) flag_o <= 1'b0;
      irq_o <= wrap_i && irqe_o;
    end
  end
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W = TK_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             ld_reload_i,
  input  logic [CNT_W-1:0] reload_d_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             wrap_o
);
  assign wrap_o = step_i && f_is_wrap(cnt_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o    <= '0;
      reload_o <= '0;
    end else begin
      if (ld_reload_i) reload_o <= reload_d_i;
      if (clr_i)       cnt_o <= '0;
      else if (step_i) cnt_o <= f_next_count(cnt_o, reload_o);
    end
  end
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W  = TK_CNT_W,
  parameter int unsigned DATA_W = TK_DATA_W,
  parameter int unsigned ADDR_W = TK_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tick_irq_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  // named internal events
  logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic             ctl_run, ctl_irqe, ctl_src, wrap_flag;
  logic             count_en, wrap_evt;
  logic [CNT_W-1:0] cnt_q, reload_q;

  tick_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i       (bus_sel_i),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wr_ctrl_o   (wr_ctrl),
    .wr_reload_o (wr_reload),
    .wr_cur_o    (wr_cur),
    .rd_ctrl_o   (rd_ctrl)
  );

  tick_ctrl_regs u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .rd_ctrl_i (rd_ctrl),
    .run_d_i   (bus_wdata_i[B_RUN]),
    .irqe_d_i  (bus_wdata_i[B_IRQE]),
    .src_d_i   (bus_wdata_i[B_SRC]),
    .wrap_i    (wrap_evt),
    .run_o     (ctl_run),
    .irqe_o    (ctl_irqe),
    .src_o     (ctl_src),
    .flag_o    (wrap_flag),
    .irq_o     (tick_irq_o)
  );

  assign count_en = ctl_run && (ctl_src || ref_tick_i);

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (count_en),
    .clr_i       (wr_cur),
    .ld_reload_i (wr_reload),
    .reload_d_i  (bus_wdata_i[CNT_W-1:0]),
    .cnt_o       (cnt_q),
    .reload_o    (reload_q),
    .wrap_o      (wrap_evt)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (bus_addr_i)
        A_CTRL: begin
          bus_rdata_o[B_RUN]  = ctl_run;
          bus_rdata_o[B_IRQE] = ctl_irqe;
          bus_rdata_o[B_SRC]  = ctl_src;
          bus_rdata_o[B_FLAG] = wrap_flag;
        end
        A_RELOAD: bus_rdata_o = {{PAD_W{1'b0}}, reload_q};
        A_CUR:    bus_rdata_o = {{PAD_W{1'b0}}, cnt_q};
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_checker.sv
module tick_checker #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick_i,
  input logic             wrap_evt,
  input logic             count_en,
  input logic             wrap_flag,
  input logic             rd_ctrl,
  input logic             wr_cur,
  input logic             ctl_run,
  input logic             ctl_irqe,
  input logic             ctl_src,
  input logic             tick_irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  assert_reload_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && cnt_q == '0 && !wr_cur) |=> (cnt_q == $past(reload_q)));

  assert_flag_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> wrap_flag);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wrap_evt) |=> !wrap_flag);

  assert_cur_write_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cnt_q == '0));

  assert_frozen_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !wr_cur) |=> $stable(cnt_q));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq_o |=> !tick_irq_o);

  assert_irq_follows_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && ctl_irqe) |=> (tick_irq_o && wrap_flag));

  assert_no_irq_without_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> !tick_irq_o);

  assert_ref_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && !ctl_src && !ref_tick_i && !wr_cur) |=> $stable(cnt_q));
endmodule

bind sys_tick_timer tick_checker #(.CNT_W(CNT_W)) u_tick_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_tick_i (ref_tick_i),
  .wrap_evt   (wrap_evt),
  .count_en   (count_en),
  .wrap_flag  (wrap_flag),
  .rd_ctrl    (rd_ctrl),
  .wr_cur     (wr_cur),
  .ctl_run    (ctl_run),
  .ctl_irqe   (ctl_irqe),
  .ctl_src    (ctl_src),
  .tick_irq_o (tick_irq_o),
  .cnt_q      (cnt_q),
  .reload_q   (reload_q)
);

// File: tb/tb_sys_tick_timer.sv
module tb_sys_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk; // 125 MHz

  sys_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [23:0] m_cnt, m_rld;
  logic        m_run, m_ie, m_src, m_flag, m_irq;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {15'd0, m_flag, 13'd0, m_src, m_ie, m_run};
      2'd1: return {8'd0, m_rld};
      2'd2: return {8'd0, m_cnt};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_run = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
    end else begin
      logic counted, wrapped;
      counted = m_run && (m_src || ref_tick);
      wrapped = counted && (m_cnt == 24'd1);
      m_irq   = wrapped && m_ie;
      if (wrapped) m_flag = 1;
      else if (sel && !wr && addr == 2'd0) m_flag = 0;
      if (sel && wr && addr == 2'd2) m_cnt = 0;
      else if (counted) m_cnt = (m_cnt != 0) ? m_cnt - 24'd1 : m_rld;
      if (sel && wr && addr == 2'd1) m_rld = wdata[23:0];
      if (sel && wr && addr == 2'd0) begin
        m_run = wdata[0]; m_ie = wdata[1]; m_src = wdata[2];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // all ops start at a falling edge and end at the next one with the bus idle
  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] d);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic read_check(input logic [1:0] a, input string tag);
    logic [31:0] e, d;
    sel = 1; wr = 0; addr = a;
    #1 e = exp_read(a); d = rdata;
    check(d === e, tag, d, e);
    @(negedge clk);
    sel = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int gap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state
    do_read(2'd0, d); check(d === 32'd0, "R9 ctrl", d, 0);
    do_read(2'd1, d); check(d === 32'd0, "R9 reload", d, 0);
    do_read(2'd2, d); check(d === 32'd0, "R9 cur", d, 0);
    check(irq === 1'b0, "R9 irq", {31'd0, irq}, 0);

    // R1: upper bits dropped
    do_write(2'd1, 32'hFFFF_FFFF);
    do_read(2'd1, d); check(d === 32'h00FF_FFFF, "R1 reload", d, 32'h00FF_FFFF);

    // R10: control bits read back, address 3 reads zero
    do_write(2'd0, 32'hFFFF_FFF4);
    do_read(2'd0, d); check(d === 32'h0000_0004, "R10 ctrl bits", d, 32'h4);
    do_read(2'd3, d); check(d === 32'd0, "R10 addr3", d, 0);
    do_write(2'd0, 32'd0);

    // R2 / R7: period of reload+1 on core clock
    do_write(2'd1, 32'd3);
    do_write(2'd2, 32'd0);
    do_write(2'd0, 32'h7);
    while (irq !== 1'b1) idle();
    idle();
    check(irq === 1'b0, "R7 pulse width", {31'd0, irq}, 0);
    gap = 1;
    while (irq !== 1'b1 && gap < 50) begin idle(); gap++; end
    check(gap == 4, "R2 period", gap, 4);

    // R3 / R4: flag set, read clears, read coinciding with a wrap keeps it
    do_read(2'd0, d);  check(d[16] === 1'b1, "R3 flag set", d, 32'h10007);
    idle();
    idle();
    do_read(2'd0, d);  check(d[16] === 1'b0, "R4 flag cleared", d, 32'h7);
    check(irq === 1'b1, "R7 irq on wrap", {31'd0, irq}, 1);
    do_read(2'd0, d);  check(d[16] === 1'b1, "R4 same-cycle wrap", d, 32'h10007);

    // R6: disable freezes the count
    do_write(2'd0, 32'd0);
    do_read(2'd2, d);
    idle(); idle(); idle();
    begin
      logic [31:0] d2;
      do_read(2'd2, d2); check(d2 === d, "R6 frozen", d2, d);
    end

    // R8 / R5: reference-strobe source
    do_write(2'd1, 32'd5);
    do_write(2'd2, 32'hDEAD_BEEF);
    do_write(2'd0, 32'h1);
    repeat (6) idle();
    do_read(2'd2, d); check(d === 32'd0, "R8 no strobe", d, 0);
    ref_tick = 1; idle(); ref_tick = 0;
    do_read(2'd2, d); check(d === 32'd5, "R5 reload after clear", d, 5);
    ref_tick = 1; idle(); ref_tick = 0;
    do_read(2'd2, d); check(d === 32'd4, "R8 strobe counts", d, 4);

    // R7: no irq when interrupt enable is clear
    do_write(2'd1, 32'd1);
    do_write(2'd0, 32'h5);
    gap = 0;
    repeat (10) begin
      idle();
      if (irq) gap++;
    end
    check(gap == 0, "R7 masked", gap, 0);

    // random phase checked against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      ref_tick = $urandom_range(0, 1);
      case (op)
        0: do_write(2'd0, {$urandom} | (($urandom_range(0, 3) != 0) ? 32'h1 : 32'h0));
        1: do_write(2'd1, {$urandom} & (($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : 32'h7));
        2: do_write(2'd2, $urandom);
        3, 4: read_check(2'd0, "R3/R4 rand ctrl");
        5: read_check(2'd1, "R1 rand reload");
        6, 7: read_check(2'd2, "R2/R5/R6/R8 rand cur");
        8: read_check(2'($urandom_range(0, 3)), "R10 rand addr");
        default: idle();
      endcase
      check(irq === m_irq, "R7 rand irq", {31'd0, irq}, {31'd0, m_irq});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule